// File: doc/BRIEF.md
# Chained Accumulator Arithmetic Unit

This unit runs one arithmetic instruction of a 16-bit machine with several accumulators. Each accepted instruction passes a source word and a destination word through a fixed chain of steps. First the incoming carry is preset. Next a core operation built from negate, add and increment primitives is applied. The result and the carry are then shifted together by one place. The shifted result is tested for a conditional skip. Last, the destination is either written or left alone.

The surrounding logic reads the register file, presents the decoded fields with `in_valid`, and one clock later receives the writeback word, its write enable, the new carry and the skip flag. All outputs are registered. The register file, the program counter and memory all sit outside the block.

Top module: `acc_arith_unit`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, `wb_data`, `wb_en`, `carry_out`, `skip` and `out_valid` are all 0.
- R2: `op_code` bit 2 holds the negate control inverted, bit 1 is add and bit 0 is increment. With S = `src_val` and D = `dst_val`, the codes and their results are:
  - 100 gives S.
  - 101 gives S+1.
  - 110 gives D+S.
  - 000 gives the two's complement negation of S.
  - 001 gives ~S.
  - 010 gives D+~S.
  - 011 gives D+~S+1.

  All results are taken modulo 2^16.
- R3: Code 111 gives the bitwise AND of S and D and produces no arithmetic carry.
- R4: `carry_mode` presets `carry_in` before the operation: 00 keeps it, 01 clears it, 10 sets it, 11 inverts it. The preset value is complemented when the core step produces a carry. That carry is the 17th bit of S+1, D+S, D+~S or D+~S+1, and for negation it is 1 exactly when S is 0. Pass, AND and complement produce no carry.
- R5: `shift_mode` acts on the 17-bit word {carry, result}:
  - 00 leaves it unchanged.
  - 01 rotates it left by one, so result bit 15 goes into the carry.
  - 10 rotates it right by one, so result bit 0 goes into the carry.
  - 11 swaps the two result bytes and leaves the carry unchanged.
- R6: `skip_mode` tests the shifted carry C and the shifted result R:
  - 000 never skips and 001 always skips.
  - 010 skips when C=0 and 011 skips when C=1.
  - 100 skips when R=0 and 101 skips when R≠0.
  - 110 skips when C=0 or R=0, and 111 skips when C=1 and R≠0.
- R7: With `no_load` high, `wb_en` stays low, while `wb_data`, `carry_out` and `skip` still carry the full outcome of the instruction.
- R8: Outputs appear on the clock edge after the one that accepts `in_valid`, and `out_valid` marks them. After an edge with `in_valid` low, `wb_en`, `skip` and `out_valid` are 0, and `wb_data` and `carry_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 3 | Core operation field, negate bit inverted |
| carry_mode | input | 2 | Carry preset field |
| shift_mode | input | 2 | Shift or byte swap field |
| skip_mode | input | 3 | Skip condition field |
| no_load | input | 1 | Suppress destination write |
| carry_in | input | 1 | Current carry flag |
| src_val | input | 16 | Source accumulator value |
| dst_val | input | 16 | Destination accumulator value |
| wb_data | output | 16 | Shifted result |
| wb_en | output | 1 | Destination write enable |
| carry_out | output | 1 | New carry flag |
| skip | output | 1 | Skip the next instruction |
| out_valid | output | 1 | Outputs belong to an accepted instruction |

## Verification
The assertions assume that `rst` is held high for at least one edge at start-up. They also assume the instruction fields are sampled only on edges where `in_valid` is high, and every code in every field is treated as legal. The properties that predict a result from earlier inputs, such as the byte swap of a passed source and the cleared carry, take for granted that the inputs are stable around the accepting edge. The stimulus drives every field on the falling edge and draws each code uniformly over its full range, including the complement carry preset and the reassigned AND code. It biases the operand words toward 0, all ones and single-bit values, so that the zero tests and the carry-out corners occur often.

// File: rtl/acc_arith_pkg.sv
package acc_arith_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_INC  = 3'd1,
    OP_ADD  = 3'd2,
    OP_AND  = 3'd3,
    OP_NEG  = 3'd4,
    OP_COM  = 3'd5,
    OP_ADC  = 3'd6,
    OP_SUB  = 3'd7
  } core_op_e;

  typedef enum logic [1:0] {
    CY_KEEP  = 2'd0,
    CY_CLEAR = 2'd1,
    CY_SET   = 2'd2,
    CY_FLIP  = 2'd3
  } cy_mode_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_ROL  = 2'd1,
    SH_ROR  = 2'd2,
    SH_SWAP = 2'd3
  } sh_mode_e;

  typedef enum logic [2:0] {
    SK_NEVER     = 3'd0,
    SK_ALWAYS    = 3'd1,
    SK_CY_ZERO   = 3'd2,
    SK_CY_ONE    = 3'd3,
    SK_RES_ZERO  = 3'd4,
    SK_RES_NZ    = 3'd5,
    SK_ANY_ZERO  = 3'd6,
    SK_BOTH_NZ   = 3'd7
  } sk_mode_e;

  // The stored negate bit is inverted relative to its meaning.
  function automatic core_op_e decode_op(input logic [2:0] enc);
    return core_op_e'({~enc[2], enc[1:0]});
  endfunction

  function automatic logic preset_carry(input cy_mode_e m, input logic c);
    case (m)
      CY_CLEAR: return 1'b0;
      CY_SET:   return 1'b1;
      CY_FLIP:  return ~c;
      default:  return c;
    endcase
  endfunction

endpackage

// File: rtl/acc_core_op.sv
module acc_core_op
  import acc_arith_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  core_op_e          op,
  input  logic [DATA_W-1:0] s_val,
  input  logic [DATA_W-1:0] d_val,
  output logic [DATA_W-1:0] res,
  output logic              cy_gen
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] s_ext, d_ext, ns_ext, one_ext, acc;

  always_comb begin
    s_ext   = {1'b0, s_val};
    d_ext   = {1'b0, d_val};
    ns_ext  = {1'b0, ~s_val};
    one_ext = EXT_W'(1);
    case (op)
      OP_PASS: acc = s_ext;
      OP_INC:  acc = s_ext + one_ext;
      OP_ADD:  acc = d_ext + s_ext;
      OP_AND:  acc = {1'b0, d_val & s_val};
      OP_NEG:  acc = ns_ext + one_ext;
      OP_COM:  acc = ns_ext;
      OP_ADC:  acc = d_ext + ns_ext;
      default: acc = d_ext + ns_ext + one_ext;
    endcase
    res    = acc[DATA_W-1:0];
    cy_gen = acc[DATA_W];
  end

  // R3: the AND code never yields an arithmetic carry
  always_comb begin
    if (op == OP_AND) assert_and_no_carry_R3: assert (!cy_gen);
  end

endmodule

// File: rtl/acc_shift.sv
module acc_shift
  import acc_arith_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  sh_mode_e          mode,
  input  logic              cy_i,
  input  logic [DATA_W-1:0] r_i,
  output logic              cy_o,
  output logic [DATA_W-1:0] r_o
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    cy_o = cy_i;
    r_o  = r_i;
    case (mode)
      SH_ROL: begin
        cy_o = r_i[DATA_W-1];
        r_o  = {r_i[DATA_W-2:0], cy_i};
      end
      SH_ROR: begin
        cy_o = r_i[0];
        r_o  = {cy_i, r_i[DATA_W-1:1]};
      end
      SH_SWAP: r_o = {r_i[HALF-1:0], r_i[DATA_W-1:HALF]};
      default: ;
    endcase
  end

  // R5: every shift variant only moves bits of the 17-bit word
  always_comb begin
    assert_shift_keeps_ones_R5: assert ($countones({cy_o, r_o}) == $countones({cy_i, r_i}));
  end

endmodule

// File: rtl/acc_skip.sv
module acc_skip
  import acc_arith_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  sk_mode_e          mode,
  input  logic              cy,
  input  logic [DATA_W-1:0] r,
  output logic              take
);
  logic r_zero;

  always_comb begin
    r_zero = (r == '0);
    case (mode)
      SK_NEVER:    take = 1'b0;
      SK_ALWAYS:   take = 1'b1;
      SK_CY_ZERO:  take = ~cy;
      SK_CY_ONE:   take = cy;
      SK_RES_ZERO: take = r_zero;
      SK_RES_NZ:   take = ~r_zero;
      SK_ANY_ZERO: take = ~cy | r_zero;
      default:     take = cy & ~r_zero;
    endcase
  end

endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
  import acc_arith_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_code,
  input  logic [1:0]        carry_mode,
  input  logic [1:0]        shift_mode,
  input  logic [2:0]        skip_mode,
  input  logic              no_load,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] dst_val,
  output logic [DATA_W-1:0] wb_data,
  output logic              wb_en,
  output logic              carry_out,
  output logic              skip,
  output logic              out_valid
);
  localparam int HALF = DATA_W / 2;

  core_op_e          op;
  logic              cy_base, cy_gen, cy_mid, cy_sh, sk_take;
  logic [DATA_W-1:0] core_res, sh_res;

  always_comb begin
    op      = decode_op(op_code);
    cy_base = preset_carry(cy_mode_e'(carry_mode), carry_in);
    cy_mid  = cy_base ^ cy_gen;
  end

  acc_core_op #(.DATA_W(DATA_W)) u_core (
    .op(op), .s_val(src_val), .d_val(dst_val), .res(core_res), .cy_gen(cy_gen)
  );

  acc_shift #(.DATA_W(DATA_W)) u_shift (
    .mode(sh_mode_e'(shift_mode)), .cy_i(cy_mid), .r_i(core_res),
    .cy_o(cy_sh), .r_o(sh_res)
  );

  acc_skip #(.DATA_W(DATA_W)) u_skip (
    .mode(sk_mode_e'(skip_mode)), .cy(cy_sh), .r(sh_res), .take(sk_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_data   <= '0;
      wb_en     <= 1'b0;
      carry_out <= 1'b0;
      skip      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wb_data   <= sh_res;
        carry_out <= cy_sh;
        skip      <= sk_take;
        wb_en     <= ~no_load;
      end else begin
        wb_en <= 1'b0;
        skip  <= 1'b0;
      end
    end
  end

  // R7: no-load suppresses the write
  assert_noload_blocks_write_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && no_load) |=> !wb_en);

  // R8: idle cycles produce no write, no skip, and hold the data
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wb_en && !skip && !out_valid && $stable(wb_data)));

  // R6: never and always skip codes
  assert_skip_never_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && skip_mode == 3'd0) |=> !skip);
  assert_skip_always_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && skip_mode == 3'd1) |=> skip);
  assert_skip_res_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && skip_mode == 3'd4) |=> (skip == (wb_data == '0)));

  // R5: a passed source with byte swap shows the swapped source
  assert_swap_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 3'b100 && shift_mode == 2'd3) |=>
      (wb_data == {$past(src_val[HALF-1:0]), $past(src_val[DATA_W-1:HALF])}));

  // R4: clear preset with a carry-free op and no rotation gives carry 0
  assert_clear_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && carry_mode == 2'd1 && op_code == 3'b100 && shift_mode == 2'd0)
      |=> !carry_out);

endmodule

// File: tb/acc_arith_unit_bench.sv
module acc_arith_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [1:0]  carry_mode = '0;
  logic [1:0]  shift_mode = '0;
  logic [2:0]  skip_mode = '0;
  logic        no_load = 1'b0;
  logic        carry_in = 1'b0;
  logic [15:0] src_val = '0;
  logic [15:0] dst_val = '0;
  logic [15:0] wb_data;
  logic        wb_en, carry_out, skip, out_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  acc_arith_unit u_acc_arith_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .carry_mode(carry_mode), .shift_mode(shift_mode), .skip_mode(skip_mode),
    .no_load(no_load), .carry_in(carry_in), .src_val(src_val), .dst_val(dst_val),
    .wb_data(wb_data), .wb_en(wb_en), .carry_out(carry_out), .skip(skip),
    .out_valid(out_valid)
  );

  // returns {skip, carry, result}
  function automatic logic [17:0] model(input logic [2:0] enc, input logic [1:0] cm,
      input logic [1:0] sm, input logic [2:0] km, input logic c,
      input logic [15:0] s, input logic [15:0] d);
    logic [16:0] t;
    logic [2:0]  op;
    logic        pc, nc, sk;
    logic [15:0] r;
    op = {~enc[2], enc[1:0]};
    case (op)
      3'd0: t = {1'b0, s};
      3'd1: t = 17'(s) + 17'd1;
      3'd2: t = 17'(s) + 17'(d);
      3'd3: t = {1'b0, s & d};
      3'd4: t = {s == 16'd0, 16'(16'd0 - s)};
      3'd5: t = {1'b0, ~s};
      3'd6: t = 17'(d) + 17'(16'(~s));
      default: t = 17'(d) + 17'(16'(~s)) + 17'd1;
    endcase
    pc = (cm == 2'd0) ? c : (cm == 2'd1) ? 1'b0 : (cm == 2'd2) ? 1'b1 : ~c;
    nc = pc ^ t[16];
    r  = t[15:0];
    if (sm == 2'd1) begin nc = t[15];  r = {t[14:0], pc ^ t[16]}; end
    else if (sm == 2'd2) begin nc = t[0]; r = {pc ^ t[16], t[15:1]}; end
    else if (sm == 2'd3) r = {t[7:0], t[15:8]};
    case (km)
      3'd0: sk = 0;
      3'd1: sk = 1;
      3'd2: sk = !nc;
      3'd3: sk = nc;
      3'd4: sk = (r == 0);
      3'd5: sk = (r != 0);
      3'd6: sk = !nc || (r == 0);
      default: sk = nc && (r != 0);
    endcase
    return {sk, nc, r};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] enc, input logic [1:0] cm, input logic [1:0] sm,
                     input logic [2:0] km, input logic nl, input logic c,
                     input logic [15:0] s, input logic [15:0] d, input string req);
    logic [17:0] e;
    e = model(enc, cm, sm, km, c, s, d);
    @(negedge clk);
    in_valid = 1; op_code = enc; carry_mode = cm; shift_mode = sm;
    skip_mode = km; no_load = nl; carry_in = c; src_val = s; dst_val = d;
    @(negedge clk);
    in_valid = 0;
    check(wb_data == e[15:0], req, "wb_data R2", wb_data, e[15:0]);
    check(carry_out == e[16], req, "carry R4", 16'(carry_out), 16'(e[16]));
    check(skip == e[17], req, "skip R6", 16'(skip), 16'(e[17]));
    check(wb_en == !nl, req, "wb_en R7", 16'(wb_en), 16'(!nl));
    check(out_valid == 1'b1, req, "out_valid R8", 16'(out_valid), 16'd1);
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h0001 << ($urandom % 16);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    logic        held_c;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    // R1: outputs clear during reset
    check(wb_data == 0 && !wb_en && !carry_out && !skip && !out_valid,
          "R1", "reset outputs", wb_data, 16'd0);
    rst = 0;
    @(negedge clk);
    check(!out_valid && !wb_en, "R1", "post reset", 16'(out_valid), 16'd0);

    // R2 directed: each logical op
    run(3'b100, 2'd0, 2'd0, 3'd0, 0, 0, 16'h1234, 16'h0F0F, "R2 pass");
    run(3'b101, 2'd0, 2'd0, 3'd4, 0, 0, 16'hFFFF, 16'h0000, "R2 inc wrap");
    run(3'b110, 2'd0, 2'd0, 3'd3, 0, 1, 16'h8000, 16'h8000, "R2 add carry");
    run(3'b000, 2'd1, 2'd0, 3'd3, 0, 0, 16'h0000, 16'h0000, "R2 neg zero");
    run(3'b001, 2'd0, 2'd0, 3'd0, 0, 0, 16'h00FF, 16'h0000, "R2 com");
    run(3'b010, 2'd2, 2'd0, 3'd2, 0, 0, 16'h0001, 16'h0001, "R2 adc");
    run(3'b011, 2'd1, 2'd0, 3'd4, 0, 0, 16'h5555, 16'h5555, "R2 sub equal");
    // R3: reassigned AND
    run(3'b111, 2'd2, 2'd0, 3'd7, 0, 0, 16'hF0F0, 16'hFF00, "R3 and");
    // R4: preset modes
    run(3'b100, 2'd3, 2'd0, 3'd3, 0, 0, 16'h0000, 16'h0000, "R4 flip");
    run(3'b101, 2'd2, 2'd0, 3'd2, 0, 0, 16'hFFFF, 16'h0000, "R4 set then carry");
    // R5: rotates and swap
    run(3'b100, 2'd2, 2'd1, 3'd0, 0, 0, 16'h8001, 16'h0000, "R5 rol");
    run(3'b100, 2'd1, 2'd2, 3'd0, 0, 0, 16'h0001, 16'h0000, "R5 ror");
    run(3'b100, 2'd2, 2'd3, 3'd3, 0, 0, 16'hAB12, 16'h0000, "R5 swap");
    // R6: either zero / both nonzero
    run(3'b100, 2'd2, 2'd0, 3'd6, 0, 0, 16'h0000, 16'h0000, "R6 any zero");
    run(3'b100, 2'd2, 2'd0, 3'd7, 0, 0, 16'h0040, 16'h0000, "R6 both nz");
    // R7: no load
    run(3'b011, 2'd0, 2'd0, 3'd4, 1, 0, 16'h0007, 16'h0007, "R7 noload");

    // R8: idle hold
    held = wb_data; held_c = carry_out;
    @(negedge clk);
    check(wb_data == held && carry_out == held_c, "R8", "idle hold", wb_data, held);
    check(!wb_en && !skip && !out_valid, "R8", "idle quiet",
          {13'd0, wb_en, skip, out_valid}, 16'd0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      run(3'($urandom), 2'($urandom), 2'($urandom), 3'($urandom), 1'($urandom),
          1'($urandom), pick(), pick(), "rand");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule